// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers thirteen external interrupt inputs: one nonmaskable pin and twelve maskable request pins numbered 0 to 11. Each input is synchronized to the core clock. The synchronized value is then checked for the event that the pin is configured to watch. A detected maskable event sets a status flag. Software reads that flag over a small synchronous register bus and clears it. A per-source enable decides whether a pending flag may reach the CPU. Among the enabled pending sources, the one with the highest programmable level is presented as a single request line plus a source vector.

A nonmaskable event always wins, whatever the enables and priority levels are. It stays pending until the CPU acknowledges it. The same event sends a one-cycle pulse to a transfer controller to set its error bit. It also sends a pulse that sets the error flag of DMA channel 0, and a pulse on every DMA channel's enable-clear line so that transfers in flight are aborted. Every enabled detected event, and every nonmaskable event, also produces a one-cycle wake pulse for the standby logic.

Register map (3-bit word address, 32-bit data): 0 = control (bit 0 selects the nonmaskable edge); 1 = sense modes; 2 = enables; 3 and 4 = priority levels; 5 = status. All configuration registers reset to zero.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `cpu_req`, `wake`, `dtc_err_set`, `dma_err_set` and `dma_en_clr` are 0 and `cpu_vec` is 0. The status, sense, enable, priority and control registers all read 0.
- R2: Control bit 0 at address 0 selects the nonmaskable edge: 0 means falling, 1 means rising. The opposite edge has no effect. A pending nonmaskable event forces `cpu_req`=1 and `cpu_vec`=0 regardless of the maskable sources. It stays pending until `cpu_ack` is high in a cycle where `cpu_vec` is 0.
- R3: The cycle in which a nonmaskable event is registered shows `dtc_err_set`=1, `dma_err_set`=1 and every bit of `dma_en_clr` at 1. All three fall back to 0 on the following cycle.
- R4: The sense mode of maskable pin n is bits [2n+1:2n] of address 1. 00 means low level, 01 means falling edge, 10 means rising edge, and 11 means both edges. A pin change that sets up before clock edge k shows in the status register after edge k+2. Status bit n is at address 5, and bit 31 of that address reads the pending nonmaskable event.
- R5: Enable bit n at address 2 gates pin n. A disabled source still latches its status flag, but it never raises `cpu_req`.
- R6: Pin n has a 4-bit priority level. Pins 0 to 7 are at address 3, bits [4n+3:4n]. Pins 8 to 11 are at address 4, bits [4(n-8)+3:4(n-8)]. Among the enabled pending sources the highest level wins, and on a tie the lower pin number wins. The winner is reported as `cpu_vec` = n+1.
- R7: A status flag clears only when a 0 is written to its bit after a read of address 5 has returned it as 1. A write without that prior read, or a write of 1, leaves the flag set. An event in the same cycle as the clear keeps the flag set.
- R8: In low-level mode the flag cannot be cleared while the pin stays low.
- R9: `wake` pulses for one cycle, together with the flag update, on any nonmaskable event or any detected event of an enabled maskable pin. A disabled pin's event does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Nonmaskable interrupt pin, asynchronous |
| irq_pin | input | 12 | Maskable interrupt pins, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | 4 | Source vector: 0 = nonmaskable, n+1 = pin n |
| cpu_ack | input | 1 | CPU acceptance of the presented vector |
| dtc_err_set | output | 1 | Pulse that sets the transfer controller error bit |
| dma_err_set | output | 1 | Pulse that sets the DMA channel 0 error flag |
| dma_en_clr | output | 4 | Pulse per DMA channel that clears its transfer enable |
| wake | output | 1 | Standby wake pulse |

## Verification
The bench targets the clear protocol. A design that cleared on any zero write, or on a write of ones, would lose the flag before software had seen it. It also holds a low-level pin low across a clear; a design that let that clear win would drop a request that is still present. Both nonmaskable edge settings are exercised. A wrong polarity would pulse the DMA abort lines on the wrong edge. An NMI raised at the same time as a maskable request must report vector 0 and then hand over to the maskable source after the acknowledge. Random enable masks, priority levels and pending sets, with many ties, expose an arbiter that prefers the higher index or ignores the enables.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_IRQ     = 12;
    localparam int PRIO_W      = 4;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int NUM_SRC     = NUM_IRQ + 1;
    localparam int VEC_W       = $clog2(NUM_SRC);
    localparam int PRIO_PER    = DATA_W / PRIO_W;
    localparam int PRIO_REGS   = (NUM_IRQ + PRIO_PER - 1) / PRIO_PER;

    localparam logic [ADDR_W-1:0] A_CTRL      = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SENSE     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_ENABLE    = ADDR_W'(2);
    localparam int                PRIO_BASE   = 3;
    localparam logic [ADDR_W-1:0] A_STATUS    = ADDR_W'(PRIO_BASE + PRIO_REGS);

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_s;

    function automatic logic sense_hit(input sense_e mode, input pin_s p);
        logic fall;
        logic rise;
        fall = p.prev & ~p.cur;
        rise = ~p.prev & p.cur;
        case (mode)
            SENSE_LOW:  return ~p.cur;
            SENSE_FALL: return fall;
            SENSE_RISE: return rise;
            default:    return fall | rise;
        endcase
    endfunction

endpackage

// File: rtl/eirq_sync_edge.sv
module eirq_sync_edge
    import ext_irq_pkg::*;
#(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output pin_s smp
);
    logic s1, s2, pv;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= IDLE;
            s2 <= IDLE;
            pv <= IDLE;
        end else begin
            s1 <= pin_async;
            s2 <= s1;
            pv <= s2;
        end
    end

    assign smp.cur  = s2;
    assign smp.prev = pv;
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import ext_irq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_IRQ-1:0]             evt,
    input  logic                           nmi_pend,
    output logic                           nmi_rise,
    output sense_e [NUM_IRQ-1:0]           sense_cfg,
    output logic [NUM_IRQ-1:0]             en_cfg,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_cfg,
    output logic [NUM_IRQ-1:0]             flags
);
    logic              wr_hit, rd_hit;
    logic              wr_status, rd_status;
    logic [NUM_IRQ-1:0] armed, clr;

    assign wr_hit    = bus_sel & bus_wr;
    assign rd_hit    = bus_sel & ~bus_wr;
    assign wr_status = wr_hit && bus_addr == A_STATUS;
    assign rd_status = rd_hit && bus_addr == A_STATUS;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_rise <= 1'b0;
            en_cfg   <= '0;
        end else if (wr_hit) begin
            if (bus_addr == A_CTRL)   nmi_rise <= bus_wdata[0];
            if (bus_addr == A_ENABLE) en_cfg   <= bus_wdata[NUM_IRQ-1:0];
        end
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_pin
        localparam logic [ADDR_W-1:0] PA = ADDR_W'(PRIO_BASE + n / PRIO_PER);
        localparam int                PO = (n % PRIO_PER) * PRIO_W;

        always_ff @(posedge clk) begin
            if (rst) begin
                sense_cfg[n] <= SENSE_LOW;
                prio_cfg[n]  <= '0;
            end else if (wr_hit) begin
                if (bus_addr == A_SENSE) sense_cfg[n] <= sense_e'(bus_wdata[2*n +: 2]);
                if (bus_addr == PA)      prio_cfg[n]  <= bus_wdata[PO +: PRIO_W];
            end
        end

        assign clr[n] = wr_status & ~bus_wdata[n] & armed[n];

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[n] <= 1'b0;
                armed[n] <= 1'b0;
            end else begin
                flags[n] <= (flags[n] & ~clr[n]) | evt[n];
                armed[n] <= (armed[n] & ~clr[n]) | (rd_status & flags[n]);
            end
        end

        // R7: a flag only drops after a status write
        p_clear_by_write_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[n]) |-> $past(wr_status));
        // R7: writing a one never clears
        p_one_keeps_r7: assert property (@(posedge clk) disable iff (rst)
            (wr_status && bus_wdata[n] && flags[n]) |=> flags[n]);
        // R7: an event in the clearing cycle wins
        p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
            evt[n] |=> flags[n]);
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata[0] = nmi_rise;
            A_SENSE:  for (int n = 0; n < NUM_IRQ; n++) bus_rdata[2*n +: 2] = sense_cfg[n];
            A_ENABLE: bus_rdata[NUM_IRQ-1:0] = en_cfg;
            A_STATUS: begin
                bus_rdata[NUM_IRQ-1:0] = flags;
                bus_rdata[DATA_W-1]    = nmi_pend;
            end
            default: begin
                for (int n = 0; n < NUM_IRQ; n++) begin
                    if (bus_addr == ADDR_W'(PRIO_BASE + n / PRIO_PER))
                        bus_rdata[(n % PRIO_PER) * PRIO_W +: PRIO_W] = prio_cfg[n];
                end
            end
        endcase
    end
endmodule

// File: rtl/eirq_arb.sv
module eirq_arb
    import ext_irq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           nmi_pend,
    input  logic [NUM_IRQ-1:0]             pend_en,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_cfg,
    output logic                           req,
    output logic [VEC_W-1:0]               vec
);
    logic              found;
    logic [PRIO_W-1:0] best_lvl;
    logic [VEC_W-1:0]  best_vec;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_vec = '0;
        for (int n = 0; n < NUM_IRQ; n++) begin
            if (pend_en[n] && (!found || prio_cfg[n] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = prio_cfg[n];
                best_vec = VEC_W'(n + 1);
            end
        end
    end

    assign req = nmi_pend | found;
    assign vec = nmi_pend ? '0 : best_vec;

    // R2: the nonmaskable source is presented first
    p_nmi_first_r2: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (req && vec == '0));
    // R5: only an enabled pending pin can be named
    p_winner_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        (req && vec != '0) |-> pend_en[vec - VEC_W'(1)]);
    // R5: no enabled work means no request
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!nmi_pend && pend_en == '0) |-> !req);
    // R6: vector stays within the source range
    p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
        vec <= VEC_W'(NUM_IRQ));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_DMA_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  nmi_pin,
    input  logic [NUM_IRQ-1:0]    irq_pin,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  cpu_req,
    output logic [VEC_W-1:0]      cpu_vec,
    input  logic                  cpu_ack,
    output logic                  dtc_err_set,
    output logic                  dma_err_set,
    output logic [NUM_DMA_CH-1:0] dma_en_clr,
    output logic                  wake
);
    pin_s                           nmi_smp;
    pin_s [NUM_IRQ-1:0]             irq_smp;
    logic [NUM_IRQ-1:0]             irq_evt;
    logic                           nmi_evt;
    logic                           nmi_rise;
    logic                           nmi_pend;
    sense_e [NUM_IRQ-1:0]           sense_cfg;
    logic [NUM_IRQ-1:0]             en_cfg;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_cfg;
    logic [NUM_IRQ-1:0]             flags;

    eirq_sync_edge #(.IDLE(1'b1)) u_nmi_sync (
        .clk(clk), .rst(rst), .pin_async(nmi_pin), .smp(nmi_smp)
    );

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
        eirq_sync_edge #(.IDLE(1'b1)) u_sync (
            .clk(clk), .rst(rst), .pin_async(irq_pin[n]), .smp(irq_smp[n])
        );
        assign irq_evt[n] = sense_hit(sense_cfg[n], irq_smp[n]);

        // R8: a held low level keeps the flag set
        p_level_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (sense_cfg[n] == SENSE_LOW && !irq_smp[n].cur) |=> flags[n]);
    end

    assign nmi_evt = nmi_rise ? (nmi_smp.cur & ~nmi_smp.prev)
                              : (~nmi_smp.cur & nmi_smp.prev);

    eirq_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(irq_evt), .nmi_pend(nmi_pend),
        .nmi_rise(nmi_rise), .sense_cfg(sense_cfg), .en_cfg(en_cfg),
        .prio_cfg(prio_cfg), .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend    <= 1'b0;
            dtc_err_set <= 1'b0;
            dma_err_set <= 1'b0;
            dma_en_clr  <= '0;
            wake        <= 1'b0;
        end else begin
            nmi_pend    <= nmi_evt | (nmi_pend & ~(cpu_ack && cpu_vec == '0));
            dtc_err_set <= nmi_evt;
            dma_err_set <= nmi_evt;
            dma_en_clr  <= {NUM_DMA_CH{nmi_evt}};
            wake        <= nmi_evt | (|(irq_evt & en_cfg));
        end
    end

    eirq_arb u_arb (
        .clk(clk), .rst(rst), .nmi_pend(nmi_pend),
        .pend_en(flags & en_cfg), .prio_cfg(prio_cfg),
        .req(cpu_req), .vec(cpu_vec)
    );

    // R3: a new nonmaskable event fires every side-effect line
    p_nmi_side_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_pend) |-> (dtc_err_set && dma_err_set && &dma_en_clr));
    // R3: side-effect pulses last one cycle
    p_nmi_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        dtc_err_set |=> !dtc_err_set);
    // R9: a nonmaskable event always wakes
    p_nmi_wake_r9: assert property (@(posedge clk) disable iff (rst)
        dtc_err_set |-> wake);
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 1'b1;
    logic [11:0] irq_pin = '1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_req;
    logic [3:0]  cpu_vec;
    logic        cpu_ack = 1'b0;
    logic        dtc_err_set, dma_err_set, wake;
    logic [3:0]  dma_en_clr;

    int nchk = 0;
    int nfail = 0;
    logic [3:0] prio_m [NI];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl uut (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack),
        .dtc_err_set(dtc_err_set), .dma_err_set(dma_err_set),
        .dma_en_clr(dma_en_clr), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all;
        logic [31:0] d;
        rd(3'd5, d);
        wr(3'd5, 32'h0);
    endtask

    task automatic ack;
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    function automatic logic [3:0] exp_vec(input logic [11:0] pend);
        int best = -1;
        for (int n = 0; n < NI; n++)
            if (pend[n] && (best < 0 || prio_m[n] > prio_m[best])) best = n;
        return (best < 0) ? 4'd0 : 4'(best + 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pa, pb;
        logic [11:0] en, sub;
        void'($urandom(32'h5eed_0017));
        for (int n = 0; n < NI; n++) prio_m[n] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", 32'(cpu_req), 0);
        chk("R1 vec", 32'(cpu_vec), 0);
        chk("R1 wake", 32'(wake), 0);
        chk("R1 dma", {dtc_err_set, dma_err_set, dma_en_clr}, 0);
        rd(3'd5, d); chk("R1 status", d, 0);
        rd(3'd1, d); chk("R1 sense", d, 0);
        rd(3'd2, d); chk("R1 enable", d, 0);
        rd(3'd0, d); chk("R1 ctrl", d, 0);

        // R4 falling edge on pin 2, R9 wake, R6 vector
        wr(3'd1, 32'h1 << 4);
        wr(3'd2, 32'h1 << 2);
        irq_pin[2] = 1'b0; settle;
        chk("R9 wake on enabled event", 32'(wake), 1);
        chk("R6 vec pin2", 32'(cpu_vec), 3);
        chk("R5 req enabled", 32'(cpu_req), 1);
        rd(3'd5, d); chk("R4 fall sets", d, 32'h4);
        irq_pin[2] = 1'b1; settle;
        chk("R4 rise ignored in fall mode wake", 32'(wake), 0);
        clear_all;
        rd(3'd5, d); chk("R7 clear after read", d, 0);

        // R7 clear protocol
        irq_pin[2] = 1'b0; settle;
        wr(3'd5, 32'h0);
        rd(3'd5, d); chk("R7 unread write keeps", d, 32'h4);
        wr(3'd5, 32'hFFF);
        rd(3'd5, d); chk("R7 write one keeps", d, 32'h4);
        wr(3'd5, 32'h0);
        rd(3'd5, d); chk("R7 armed write clears", d, 0);
        irq_pin[2] = 1'b1; settle;

        // R4 rising edge on pin 5
        wr(3'd1, (32'h1 << 4) | (32'h2 << 10));
        irq_pin[5] = 1'b0; settle;
        rd(3'd5, d); chk("R4 fall ignored in rise mode", d, 0);
        irq_pin[5] = 1'b1; settle;
        rd(3'd5, d); chk("R4 rise sets", d, 32'h20);
        clear_all;

        // R4 both edges on pin 7
        wr(3'd1, (32'h1 << 4) | (32'h2 << 10) | (32'h3 << 14));
        irq_pin[7] = 1'b0; settle;
        rd(3'd5, d); chk("R4 both fall", d, 32'h80);
        clear_all;
        irq_pin[7] = 1'b1; settle;
        rd(3'd5, d); chk("R4 both rise", d, 32'h80);
        clear_all;

        // R8 level mode on pin 3
        irq_pin[3] = 1'b0; settle;
        clear_all;
        rd(3'd5, d); chk("R8 level holds flag", d, 32'h8);
        irq_pin[3] = 1'b1; settle;
        clear_all;
        rd(3'd5, d); chk("R8 level released clears", d, 0);

        // R5 disabled source
        wr(3'd2, 32'h0);
        irq_pin[2] = 1'b0; settle;
        chk("R9 no wake when disabled", 32'(wake), 0);
        chk("R5 no req when disabled", 32'(cpu_req), 0);
        rd(3'd5, d); chk("R5 flag still latches", d, 32'h4);
        wr(3'd2, 32'h4);
        chk("R5 req after enable", 32'(cpu_req), 1);

        // R2 NMI preempts pending pin 2, R3 side effects
        nmi_pin = 1'b0; settle;
        chk("R3 dtc pulse", 32'(dtc_err_set), 1);
        chk("R3 dma err pulse", 32'(dma_err_set), 1);
        chk("R3 dma abort all", 32'(dma_en_clr), 32'hF);
        chk("R9 nmi wake", 32'(wake), 1);
        chk("R2 nmi vec", 32'(cpu_vec), 0);
        chk("R2 nmi req", 32'(cpu_req), 1);
        @(negedge clk);
        chk("R3 single pulse", {dtc_err_set, dma_err_set, dma_en_clr}, 0);
        rd(3'd5, d); chk("R4 nmi status bit", d, 32'h8000_0004);
        ack;
        chk("R2 handover vec", 32'(cpu_vec), 3);
        clear_all;
        irq_pin[2] = 1'b1; settle;
        chk("R2 req idle", 32'(cpu_req), 0);
        nmi_pin = 1'b1; settle;
        chk("R2 rise ignored in fall mode", 32'(dtc_err_set), 0);
        chk("R2 no req", 32'(cpu_req), 0);
        wr(3'd0, 32'h1);
        nmi_pin = 1'b0; settle;
        chk("R2 fall ignored in rise mode", 32'(dtc_err_set), 0);
        nmi_pin = 1'b1; settle;
        chk("R3 rise mode pulse", 32'(dma_err_set), 1);
        chk("R2 rise mode vec", {31'b0, cpu_req}, 1);
        ack;
        chk("R2 ack clears", 32'(cpu_req), 0);

        // R6 random priorities, enables and pending sets
        wr(3'd1, 32'h0055_5555);
        for (int it = 0; it < 40; it++) begin
            en = 12'($urandom);
            pa = $urandom;
            pb = $urandom & 32'h0000_FFFF;
            if (it % 4 == 0) begin pa = '0; pb = '0; end
            for (int n = 0; n < 8; n++) prio_m[n] = pa[4*n +: 4];
            for (int n = 8; n < NI; n++) prio_m[n] = pb[4*(n-8) +: 4];
            wr(3'd2, 32'(en));
            wr(3'd3, pa);
            wr(3'd4, pb);
            sub = 12'($urandom);
            irq_pin = ~sub;
            repeat (3) @(negedge clk);
            irq_pin = '1;
            settle;
            rd(3'd5, d); chk("R4 random flags", d, 32'(sub));
            chk("R5 random req", 32'(cpu_req), 32'(|(sub & en)));
            chk("R6 random vec", 32'(cpu_vec), 32'(exp_vec(sub & en)));
            clear_all;
            rd(3'd5, d); chk("R7 random clear", d, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule